// File: doc/BRIEF.md
# Split-Transaction Burst Bus Arbiter

This block decides who drives a shared 64-bit split bus. Each transfer on the bus has two separately arbitrated halves. In the request half, a master sends either a read address or a write's address and data. In the response half, the slave returns read data or a write acknowledgement once its memory access has completed. The memory takes at least one cycle, and the arbiter never knows in advance how long. A master raises a one-cycle post with a direction and a size in bits. Later the slave raises a one-cycle completion carrying that master's tag. In both cases the arbiter queues a candidate.

Every cycle at most one tenure is granted. Its beats fill the cycles right after the grant. A new grant is made only when none of its beats would fall on a cycle that is already reserved, so bursts can follow each other with no gap. A waiting response always wins over a new request. Among new requests, writes win over reads, and within each class the oldest candidate goes first. The grant outputs give the master tag, the phase, the direction and the number of beats. Two further outputs show, cycle by cycle, whether a beat is on the bus and whose it is.

Top module: `split_bus_arbiter`

## Requirements
- R1: After reset no grant is offered and no beat is on the bus.
- R2: A write request tenure lasts ceil(size/64) beats, and a size of 0 counts as one beat. A read request tenure is always exactly one beat.
- R3: A read response tenure lasts ceil(size/64) beats, using the size given when the read was posted. A write response tenure is always exactly one beat.
- R4: A grant in cycle t with n beats makes busBeat high with busId equal to the granted tag in cycles t+1 to t+n. The next grant comes no earlier than cycle t+n, so it can never overlap reserved beats.
- R5: When any response is waiting, the grant goes to a response (grantResp = 1).
- R6: When no response is waiting, a waiting write request is granted before any read request (grantWrite = 1 when grantResp = 0).
- R7: Within each class (responses, write requests, read requests), candidates are granted in the order in which they entered. Candidates that entered in the same cycle go lowest tag first. Responses enter in the order of completion.
- R8: A post from a master that still has a transaction outstanding is ignored, and its direction and size are not stored.
- R9: A completion is ignored unless the tagged master's request phase has already been granted and no completion has yet been taken for it.
- R10: At most one grant is made per cycle. A grant is made in every cycle in which a candidate waits and no reserved beat remains after the current cycle.
- R11: A master whose response is granted in cycle t may post again from cycle t+1. A post in cycle t itself is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| postValid | input | NUM_MASTERS | One-cycle post of a new transaction, one bit per master |
| postWrite | input | NUM_MASTERS | Direction of each post: 1 write, 0 read |
| postSize | input | NUM_MASTERS*SIZE_W | Transfer size in bits per master, master i at bits i*SIZE_W upward |
| cplValid | input | 1 | One-cycle completion from the memory side |
| cplId | input | ID_W | Master tag of the completed access |
| grantValid | output | 1 | A tenure is granted this cycle |
| grantId | output | ID_W | Master tag of the granted tenure |
| grantResp | output | 1 | 1 for a response tenure, 0 for a request tenure |
| grantWrite | output | 1 | Direction of the granted transaction |
| grantBeats | output | BEAT_W | Number of beats of the granted tenure |
| busBeat | output | 1 | A reserved beat occupies the bus this cycle |
| busId | output | ID_W | Tag of the tenure owning the current beat |

## Verification
The assertions assume that posts and completions last one cycle each and that cplId always names an existing master. They make no other assumption about the traffic. The priority and work-conservation properties compare the grant against the datapath's own availability flags, not against the stimulus. The random stimulus posts only from masters the bench model sees as idle, and it completes only masters whose request phase has been granted. The exceptions are a small share of deliberately redundant posts and stray completions. Directed phases push these cases to their limits: a post in the very cycle of the response grant, repeated posts while a transaction is outstanding, and completions for idle or still-queued masters.

// File: rtl/sba_pkg.sv
`timescale 1ns/1ps
package sba_pkg;

  // Candidate classes, index order is grant priority
  localparam int NUM_CLASSES = 3;
  localparam int CLS_RSP     = 0;
  localparam int CLS_WR      = 1;
  localparam int CLS_RD      = 2;

  // Width of the tag field carried by the strobe struct (up to 256 masters)
  localparam int ID_FIELD_W  = 8;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_REQ  = 2'd1,
    SLOT_MEM  = 2'd2,
    SLOT_RSP  = 2'd3
  } slotState_e;

  typedef struct packed {
    logic                  fire;
    logic                  isResp;
    logic [ID_FIELD_W-1:0] id;
  } grantStrobe_t;

endpackage

// File: rtl/sba_datapath.sv
`timescale 1ns/1ps
module sba_datapath import sba_pkg::*; #(
  parameter int NUM_MASTERS = 4,
  parameter int SIZE_W      = 9,
  parameter int BUS_W       = 64,
  parameter int ID_W        = 2,
  parameter int BEAT_W      = 4
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [NUM_MASTERS-1:0]                postValid,
  input  logic [NUM_MASTERS-1:0]                postWrite,
  input  logic [NUM_MASTERS*SIZE_W-1:0]         postSize,
  input  logic                                  cplValid,
  input  logic [ID_W-1:0]                       cplId,
  input  grantStrobe_t                          strobe,
  output logic [NUM_CLASSES-1:0]                headAvail,
  output logic [NUM_CLASSES-1:0][ID_W-1:0]      headId,
  output logic [NUM_CLASSES-1:0][BEAT_W-1:0]    headBeats,
  output logic                                  rspHeadWrite
);

  localparam int N = NUM_MASTERS;

  function automatic logic [BEAT_W-1:0] sizeToBeats(input logic [SIZE_W-1:0] sz);
    int unsigned q;
    q = (32'(sz) + 32'(BUS_W) - 32'd1) / 32'(BUS_W);
    if (q == 0) q = 1;
    return BEAT_W'(q);
  endfunction

  logic [N-1:0]             enterVec;
  logic [N-1:0]             queuedVec;
  logic [N-1:0]             inRsp;
  logic [N-1:0]             inWrReq;
  logic [N-1:0]             inRdReq;
  logic [N-1:0]             slotWr;
  logic [N-1:0][BEAT_W-1:0] reqBeats;
  logic [N-1:0][BEAT_W-1:0] rspBeats;

  // Per-master transaction slot
  for (genvar i = 0; i < N; i++) begin : g_slot
    slotState_e        stQ, stD;
    logic              wrQ;
    logic [SIZE_W-1:0] sizeQ;
    logic              hit;
    logic [BEAT_W-1:0] dataBeats;

    assign hit = strobe.fire && (strobe.id == ID_FIELD_W'(i));

    always_comb begin
      stD = stQ;
      case (stQ)
        SLOT_IDLE: if (postValid[i])                            stD = SLOT_REQ;
        SLOT_REQ:  if (hit && !strobe.isResp)                   stD = SLOT_MEM;
        SLOT_MEM:  if (cplValid && (cplId == ID_W'(i)))         stD = SLOT_RSP;
        SLOT_RSP:  if (hit && strobe.isResp)                    stD = SLOT_IDLE;
        default:                                                stD = SLOT_IDLE;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stQ   <= SLOT_IDLE;
        wrQ   <= 1'b0;
        sizeQ <= '0;
      end else begin
        stQ <= stD;
        if (stQ == SLOT_IDLE && postValid[i]) begin
          wrQ   <= postWrite[i];
          sizeQ <= postSize[i*SIZE_W +: SIZE_W];
        end
      end
    end

    assign dataBeats    = sizeToBeats(sizeQ);
    assign enterVec[i]  = ((stQ == SLOT_IDLE) && (stD == SLOT_REQ)) ||
                          ((stQ == SLOT_MEM)  && (stD == SLOT_RSP));
    assign queuedVec[i] = (stQ == SLOT_REQ) || (stQ == SLOT_RSP);
    assign inRsp[i]     = (stQ == SLOT_RSP);
    assign inWrReq[i]   = (stQ == SLOT_REQ) && wrQ;
    assign inRdReq[i]   = (stQ == SLOT_REQ) && !wrQ;
    assign slotWr[i]    = wrQ;
    assign reqBeats[i]  = wrQ ? dataBeats : BEAT_W'(1);
    assign rspBeats[i]  = wrQ ? BEAT_W'(1) : dataBeats;
  end

  // Age matrix: olderQ[a][b] set when a entered its queue before b
  logic [N-1:0][N-1:0] olderQ;
  logic [N-1:0][N-1:0] olderCol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      olderQ <= '0;
    end else begin
      for (int a = 0; a < N; a++) begin
        for (int b = 0; b < N; b++) begin
          if (a != b) begin
            if (enterVec[b])
              olderQ[a][b] <= queuedVec[a] || (enterVec[a] && (a < b));
            else if (enterVec[a])
              olderQ[a][b] <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++)
      for (int a = 0; a < N; a++)
        olderCol[i][a] = olderQ[a][i];
  end

  logic [NUM_CLASSES-1:0][N-1:0] classMask;
  assign classMask[CLS_RSP] = inRsp;
  assign classMask[CLS_WR]  = inWrReq;
  assign classMask[CLS_RD]  = inRdReq;

  // Oldest member of each class
  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
    logic [N-1:0]    headOh;
    logic [ID_W-1:0] idx;

    always_comb begin
      headOh = '0;
      for (int i = 0; i < N; i++)
        headOh[i] = classMask[c][i] && ((classMask[c] & olderCol[i]) == '0);
      idx = '0;
      for (int i = 0; i < N; i++)
        if (headOh[i]) idx = ID_W'(i);
    end

    assign headAvail[c] = |classMask[c];
    assign headId[c]    = idx;
    if (c == CLS_RSP) begin : g_rsp
      assign headBeats[c] = rspBeats[idx];
    end else begin : g_req
      assign headBeats[c] = reqBeats[idx];
    end
  end

  assign rspHeadWrite = slotWr[headId[CLS_RSP]];

endmodule

// File: rtl/sba_ctrl.sv
`timescale 1ns/1ps
module sba_ctrl import sba_pkg::*; #(
  parameter int ID_W   = 2,
  parameter int BEAT_W = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_CLASSES-1:0]             headAvail,
  input  logic [NUM_CLASSES-1:0][ID_W-1:0]   headId,
  input  logic [NUM_CLASSES-1:0][BEAT_W-1:0] headBeats,
  input  logic                               rspHeadWrite,
  output grantStrobe_t                       strobe,
  output logic                               grantValid,
  output logic [ID_W-1:0]                    grantId,
  output logic                               grantResp,
  output logic                               grantWrite,
  output logic [BEAT_W-1:0]                  grantBeats,
  output logic                               busBeat,
  output logic [ID_W-1:0]                    busId
);

  logic [BEAT_W-1:0] busyQ;     // reserved beats from this cycle on
  logic [ID_W-1:0]   ownerQ;
  logic              slotOpen;
  logic              pickAny;
  logic [1:0]        pickCls;

  always_comb begin
    slotOpen = (busyQ <= BEAT_W'(1));
    pickAny  = 1'b0;
    pickCls  = 2'(CLS_RSP);
    for (int c = 0; c < NUM_CLASSES; c++) begin
      if (!pickAny && headAvail[c]) begin
        pickAny = 1'b1;
        pickCls = 2'(c);
      end
    end
  end

  assign grantValid = slotOpen && pickAny;
  assign grantId    = headId[pickCls];
  assign grantResp  = (pickCls == 2'(CLS_RSP));
  assign grantWrite = grantResp ? rspHeadWrite : (pickCls == 2'(CLS_WR));
  assign grantBeats = headBeats[pickCls];

  assign strobe = '{fire: grantValid, isResp: grantResp, id: ID_FIELD_W'(grantId)};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= '0;
      ownerQ <= '0;
    end else if (grantValid) begin
      busyQ  <= grantBeats;
      ownerQ <= grantId;
    end else if (busyQ != '0) begin
      busyQ  <= busyQ - BEAT_W'(1);
    end
  end

  assign busBeat = (busyQ != '0);
  assign busId   = ownerQ;

endmodule

// File: rtl/split_bus_arbiter.sv
`timescale 1ns/1ps
module split_bus_arbiter import sba_pkg::*; #(
  parameter int NUM_MASTERS = 4,
  parameter int SIZE_W      = 9,
  parameter int BUS_W       = 64,
  parameter int ID_W        = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  parameter int MAX_BEATS   = ((1 << SIZE_W) - 1 + BUS_W - 1) / BUS_W,
  parameter int BEAT_W      = $clog2(MAX_BEATS + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_MASTERS-1:0]        postValid,
  input  logic [NUM_MASTERS-1:0]        postWrite,
  input  logic [NUM_MASTERS*SIZE_W-1:0] postSize,
  input  logic                          cplValid,
  input  logic [ID_W-1:0]               cplId,
  output logic                          grantValid,
  output logic [ID_W-1:0]               grantId,
  output logic                          grantResp,
  output logic                          grantWrite,
  output logic [BEAT_W-1:0]             grantBeats,
  output logic                          busBeat,
  output logic [ID_W-1:0]               busId
);

  grantStrobe_t                       strobe;
  logic [NUM_CLASSES-1:0]             headAvail;
  logic [NUM_CLASSES-1:0][ID_W-1:0]   headId;
  logic [NUM_CLASSES-1:0][BEAT_W-1:0] headBeats;
  logic                               rspHeadWrite;

  sba_datapath #(
    .NUM_MASTERS(NUM_MASTERS), .SIZE_W(SIZE_W), .BUS_W(BUS_W),
    .ID_W(ID_W), .BEAT_W(BEAT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .postValid(postValid), .postWrite(postWrite), .postSize(postSize),
    .cplValid(cplValid), .cplId(cplId),
    .strobe(strobe),
    .headAvail(headAvail), .headId(headId), .headBeats(headBeats),
    .rspHeadWrite(rspHeadWrite)
  );

  sba_ctrl #(.ID_W(ID_W), .BEAT_W(BEAT_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .headAvail(headAvail), .headId(headId), .headBeats(headBeats),
    .rspHeadWrite(rspHeadWrite),
    .strobe(strobe),
    .grantValid(grantValid), .grantId(grantId), .grantResp(grantResp),
    .grantWrite(grantWrite), .grantBeats(grantBeats),
    .busBeat(busBeat), .busId(busId)
  );

endmodule

// File: rtl/sba_checker.sv
`timescale 1ns/1ps
module sba_checker import sba_pkg::*; #(
  parameter int ID_W      = 2,
  parameter int BEAT_W    = 4,
  parameter int MAX_BEATS = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   grantValid,
  input logic [ID_W-1:0]        grantId,
  input logic                   grantResp,
  input logic                   grantWrite,
  input logic [BEAT_W-1:0]      grantBeats,
  input logic                   busBeat,
  input logic [ID_W-1:0]        busId,
  input logic [NUM_CLASSES-1:0] headAvail
);

  AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (grantBeats != '0) && (int'(grantBeats) <= MAX_BEATS)); // R2

  AST_RD_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && !grantResp && !grantWrite |-> grantBeats == BEAT_W'(1)); // R2

  AST_WR_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && grantResp && grantWrite |-> grantBeats == BEAT_W'(1)); // R3

  AST_BEAT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |=> busBeat && (busId == $past(grantId))); // R4

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && (grantBeats > BEAT_W'(1)) |=> !grantValid); // R4

  AST_RSP_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && headAvail[CLS_RSP] |-> grantResp); // R5

  AST_WR_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && !grantResp && headAvail[CLS_WR] |-> grantWrite); // R6

  AST_WORK_CONSERVING: assert property (@(posedge clk) disable iff (!rstN)
    !busBeat && (headAvail != '0) |-> grantValid); // R10

endmodule

bind split_bus_arbiter sba_checker #(
  .ID_W(ID_W), .BEAT_W(BEAT_W), .MAX_BEATS(MAX_BEATS)
) chk_i (
  .clk(clk), .rstN(rstN),
  .grantValid(grantValid), .grantId(grantId), .grantResp(grantResp),
  .grantWrite(grantWrite), .grantBeats(grantBeats),
  .busBeat(busBeat), .busId(busId), .headAvail(headAvail)
);

// File: tb/split_bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module split_bus_arbiter_tb_top;

  localparam int N      = 4;
  localparam int SIZE_W = 9;
  localparam int BUS_W  = 64;
  localparam int ID_W   = 2;
  localparam int BEAT_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [N-1:0]        postValid;
  logic [N-1:0]        postWrite;
  logic [N*SIZE_W-1:0] postSize;
  logic                cplValid;
  logic [ID_W-1:0]     cplId;
  logic                grantValid, grantResp, grantWrite, busBeat;
  logic [ID_W-1:0]     grantId, busId;
  logic [BEAT_W-1:0]   grantBeats;

  split_bus_arbiter #(.NUM_MASTERS(N), .SIZE_W(SIZE_W), .BUS_W(BUS_W)) dut_i (
    .clk(clk), .rstN(rstN),
    .postValid(postValid), .postWrite(postWrite), .postSize(postSize),
    .cplValid(cplValid), .cplId(cplId),
    .grantValid(grantValid), .grantId(grantId), .grantResp(grantResp),
    .grantWrite(grantWrite), .grantBeats(grantBeats),
    .busBeat(busBeat), .busId(busId)
  );

  int    checks = 0;
  int    failures = 0;
  string phaseTag = "R10";

  // Bench model: 0 idle, 1 request waiting, 2 memory busy, 3 response waiting
  int     mSt[N];
  bit     mWr[N];
  int     mSize[N];
  longint mStamp[N];
  longint stampCtr = 0;
  int     mBusy = 0;
  int     mOwner = 0;

  bit eValid, eResp, eWrite;
  int eId, eBeats;

  // Stimulus for the next cycle
  bit [N-1:0] dPv, dPw;
  int         dSz[N];
  bit         dCv;
  int         dCid;

  function automatic int ceilBeats(int sz);
    return (sz == 0) ? 1 : (sz + BUS_W - 1) / BUS_W;
  endfunction

  function automatic void predict();
    eValid = 0; eResp = 0; eWrite = 0; eId = 0; eBeats = 0;
    if (mBusy <= 1) begin
      for (int cls = 0; cls < 3; cls++) begin
        longint best;
        int     bi;
        best = 0;
        bi = -1;
        if (!eValid) begin
          for (int i = 0; i < N; i++) begin
            bit inCls;
            inCls = (cls == 0) ? (mSt[i] == 3) :
                    (cls == 1) ? (mSt[i] == 1 && mWr[i]) : (mSt[i] == 1 && !mWr[i]);
            if (inCls && (bi < 0 || mStamp[i] < best)) begin
              bi = i;
              best = mStamp[i];
            end
          end
          if (bi >= 0) begin
            eValid = 1;
            eId    = bi;
            eResp  = (cls == 0);
            eWrite = mWr[bi];
            if (cls == 0) eBeats = mWr[bi] ? 1 : ceilBeats(mSize[bi]);
            else          eBeats = mWr[bi] ? ceilBeats(mSize[bi]) : 1;
          end
        end
      end
    end
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareOutputs();
    check(grantValid == eValid, phaseTag, "grantValid", int'(grantValid), int'(eValid));
    if (grantValid && eValid) begin
      check(int'(grantId) == eId, "R7", "grantId", int'(grantId), eId);
      check(grantResp == eResp, "R5", "grantResp", int'(grantResp), int'(eResp));
      check(grantWrite == eWrite, "R6", "grantWrite", int'(grantWrite), int'(eWrite));
      check(int'(grantBeats) == eBeats, eResp ? "R3" : "R2", "grantBeats",
            int'(grantBeats), eBeats);
    end
    check(busBeat == (mBusy > 0), "R4", "busBeat", int'(busBeat), int'(mBusy > 0));
    if (mBusy > 0)
      check(int'(busId) == mOwner, "R4", "busId", int'(busId), mOwner);
  endtask

  task automatic clearStim();
    dPv = '0; dPw = '0; dCv = 0; dCid = 0;
    for (int i = 0; i < N; i++) dSz[i] = 0;
  endtask

  // One cycle: compare at the falling edge, drive, advance model, wait a cycle
  task automatic step();
    int old[N];
    predict();
    compareOutputs();
    postValid = dPv;
    postWrite = dPw;
    for (int i = 0; i < N; i++) postSize[i*SIZE_W +: SIZE_W] = SIZE_W'(dSz[i]);
    cplValid = dCv;
    cplId    = ID_W'(dCid);
    for (int i = 0; i < N; i++) old[i] = mSt[i];
    if (eValid) begin
      mBusy  = eBeats;
      mOwner = eId;
      mSt[eId] = eResp ? 0 : 2;
    end else if (mBusy > 0) begin
      mBusy--;
    end
    for (int i = 0; i < N; i++) begin
      if (old[i] == 0 && dPv[i]) begin
        mSt[i] = 1; mWr[i] = dPw[i]; mSize[i] = dSz[i];
        mStamp[i] = stampCtr; stampCtr++;
      end
    end
    if (dCv && old[dCid] == 2) begin
      mSt[dCid] = 3; mStamp[dCid] = stampCtr; stampCtr++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int pickSize();
    case ($urandom % 8)
      0: return 0;
      1: return 64;
      2: return 65;
      3: return 128;
      4: return 511;
      5: return 1;
      default: return int'($urandom % 512);
    endcase
  endfunction

  task automatic drain(int cycles);
    for (int k = 0; k < cycles; k++) begin
      clearStim();
      for (int i = 0; i < N; i++)
        if (!dCv && mSt[i] == 2) begin dCv = 1; dCid = i; end
      step();
    end
  endtask

  task automatic printSummary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    printSummary();
    $finish;
  end

  initial begin
    int armed;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin mSt[i] = 0; mWr[i] = 0; mSize[i] = 0; mStamp[i] = 0; end
    postValid = '0; postWrite = '0; postSize = '0; cplValid = 0; cplId = '0;
    clearStim();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check(grantValid == 1'b0, "R1", "grantValid after reset", int'(grantValid), 0);
    check(busBeat == 1'b0, "R1", "busBeat after reset", int'(busBeat), 0);

    // R7 / R6 / R2: all masters post together, mixed directions and sizes
    phaseTag = "R7";
    clearStim();
    dPv = 4'b1111; dPw = 4'b0110;
    dSz[0] = 64; dSz[1] = 128; dSz[2] = 0; dSz[3] = 300;
    step();
    for (int k = 0; k < 30; k++) begin
      clearStim();
      for (int i = N - 1; i >= 0; i--)
        if (!dCv && mSt[i] == 2) begin dCv = 1; dCid = i; end
      step();
    end
    drain(20);

    // R8: repeated posts while outstanding are ignored
    phaseTag = "R8";
    clearStim();
    dPv[2] = 1; dPw[2] = 1; dSz[2] = 256;
    step();
    for (int k = 0; k < 8; k++) begin
      clearStim();
      dPv[2] = 1; dPw[2] = 0; dSz[2] = 64;
      step();
    end
    drain(20);

    // R9: stray completions for idle and still-queued masters
    phaseTag = "R9";
    clearStim();
    dCv = 1; dCid = 1;
    step();
    clearStim();
    dPv[1] = 1; dPw[1] = 0; dSz[1] = 511;
    dPv[3] = 1; dPw[3] = 1; dSz[3] = 448;
    step();
    clearStim();
    dCv = 1; dCid = 1;
    step();
    for (int k = 0; k < 6; k++) begin
      clearStim();
      dCv = 1; dCid = 0;
      step();
    end
    drain(30);

    // R11: re-post in the cycle of the response grant and in the next one
    phaseTag = "R11";
    clearStim();
    dPv[0] = 1; dPw[0] = 1; dSz[0] = 64;
    step();
    armed = 0;
    for (int k = 0; k < 30; k++) begin
      predict();
      clearStim();
      if (mSt[0] == 2) begin dCv = 1; dCid = 0; end
      if (armed == 0 && eValid && eResp && eId == 0) begin
        dPv[0] = 1; dPw[0] = 0; dSz[0] = 192; armed = 1;
      end else if (armed == 1) begin
        dPv[0] = 1; dPw[0] = 0; dSz[0] = 128; armed = 2;
      end
      step();
    end
    drain(20);

    // Constrained random traffic
    phaseTag = "R10";
    for (int k = 0; k < 4000; k++) begin
      int memList[N];
      int nMem;
      clearStim();
      nMem = 0;
      for (int i = 0; i < N; i++) begin
        if ((mSt[i] == 0 && ($urandom % 3) == 0) || ($urandom % 16) == 0) begin
          dPv[i] = 1; dPw[i] = $urandom % 2; dSz[i] = pickSize();
        end
        if (mSt[i] == 2) begin memList[nMem] = i; nMem++; end
      end
      if (nMem > 0 && ($urandom % 3) == 0) begin
        dCv = 1; dCid = memList[$urandom % nMem];
      end else if (($urandom % 16) == 0) begin
        dCv = 1; dCid = int'($urandom % N);
      end
      step();
    end
    drain(40);

    printSummary();
    $finish;
  end

endmodule